// File: doc/BRIEF.md
# Adaptive-Depth SPI FIFO Pair

This block holds the transmit and receive data queues of an SPI master. Each queue has room for 32 words of 32 bits. How many of those slots may actually be used depends on a wide-queue enable and on the configured frame length. A register interface pushes transmit words and pops receive words. A shift engine pops transmit words and pushes received frames. The block reports empty, full and almost-full (one slot short of the usable depth) for each queue. It also detects a receive word that arrives while the receive queue is full.

The usable depth lives in a small depth-mode state machine with four states:
- `DM_COMPAT`: 4 slots.
- `DM_NARROW`: all 32 slots.
- `DM_MID`: 16 slots.
- `DM_WIDE`: 8 slots.

The mode is chosen again on every configuration write, and a soft reset returns it to `DM_COMPAT`.

Each queue also keeps an occupancy state machine with four states: `OCC_EMPTY`, `OCC_PART`, `OCC_NEAR` (one short of the depth) and `OCC_FULL` (at or above the depth). Push, pop, a depth change and soft reset move it between states. Its flags are decoded from the state.

When the depth shrinks below the current occupancy, the words already held are kept. They drain in order, and pushes are refused until the occupancy falls below the new depth.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset, and after a configuration write with `cfg_big`=0, the usable depth of each queue is 4.
- R2: A configuration write with `cfg_big`=1 sets the depth from `cfg_fsize`:
  - 32 for a frame length of 8 or less,
  - 16 for a frame length of 9 to 16,
  - 8 for a frame length above 16.
- R3: A transmit push while `tx_full`=1 is discarded: the stored words and their order are unchanged.
- R4: Each queue's flags follow its occupancy at the clock edge of the push or pop:
  - `*_empty` is 1 at occupancy 0,
  - `*_full_next` is 1 at occupancy equal to depth-1,
  - `*_full` is 1 at occupancy of depth or more.
- R5: A receive push while `rx_full`=1 drops the word and sets both `rx_ovf` and `rx_ovf_irq` at that edge.
- R6: A receive pop clears `rx_ovf` unless an overflow happens in the same cycle. `rx_ovf_irq` stays set until `ovf_clr` is pulsed.
- R7: The read-data output of each queue shows the oldest word (first in, first out). It shows 0 when the queue is empty, and a pop of an empty queue changes nothing.
- R8: After reset both empty flags are 1, and the full, almost-full and overflow outputs are 0.
- R9: A `soft_rst` pulse empties both queues, clears both overflow outputs and returns the depth to 4.
- R10: The depth changes only on a configuration write. Words held beyond a reduced depth stay and drain in order, and pushes are refused until occupancy is below the new depth.
- R11: When a push and a pop arrive in the same cycle, whether the push is accepted depends on the occupancy before the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous clear of both queues, both flags and the depth |
| cfg_wr | input | 1 | Configuration write strobe; the depth is re-evaluated |
| cfg_big | input | 1 | Wide-queue enable, sampled on `cfg_wr` |
| cfg_fsize | input | 6 | Frame length in bits, sampled on `cfg_wr` |
| tx_push | input | 1 | Write a transmit word |
| tx_wdata | input | 32 | Transmit word to write |
| tx_pop | input | 1 | Shift engine takes the oldest transmit word |
| tx_rdata | output | 32 | Oldest transmit word, or 0 when empty |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit occupancy at or above the depth |
| tx_full_next | output | 1 | Transmit occupancy equal to depth-1 |
| rx_push | input | 1 | Received frame arrives from the shift engine |
| rx_wdata | input | 32 | Received word |
| rx_pop | input | 1 | Receive data read |
| rx_rdata | output | 32 | Oldest receive word, or 0 when empty |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive occupancy at or above the depth |
| rx_full_next | output | 1 | Receive occupancy equal to depth-1 |
| ovf_clr | input | 1 | Clears the latched overflow interrupt |
| rx_ovf | output | 1 | Overflow status, cleared by a receive pop |
| rx_ovf_irq | output | 1 | Latched overflow interrupt, cleared by `ovf_clr` |

## Verification
The hardest state to reach is a queue holding more words than its usable depth. To get there, the stimulus selects the 32-slot mode, fills the transmit queue to 20 words, and then writes a frame length that shrinks the depth to 8. Pushes must then be refused, and the flags must pass through full, almost-full and partial while the 20 words drain in order. Overflow is reached by filling the receive queue at depth 4 and pushing once more. A random phase then mixes configuration writes, simultaneous push and pop, and rare soft resets. Throughout, a queue-based model is compared on every clock.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    // Occupancy class of one queue relative to its usable depth
    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PART,
        OCC_NEAR,
        OCC_FULL
    } occ_e;

    // Usable-depth mode selected by configuration writes
    typedef enum logic [1:0] {
        DM_COMPAT,
        DM_NARROW,
        DM_MID,
        DM_WIDE
    } dmode_e;

endpackage

// File: rtl/spi_fifo_depth_sel.sv
module spi_fifo_depth_sel
    import spi_fifo_pkg::*;
#(
    parameter int CAP        = 32,
    parameter int SMALL      = 4,
    parameter int FSZ_W      = 6,
    parameter int NARROW_MAX = 8,
    parameter int MID_MAX    = 16,
    localparam int CW        = $clog2(CAP) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_wr,
    input  logic             cfg_big,
    input  logic [FSZ_W-1:0] cfg_fsize,
    output logic [CW-1:0]    depth_next
);

    localparam logic [FSZ_W-1:0] LIM_NARROW = FSZ_W'(NARROW_MAX);
    localparam logic [FSZ_W-1:0] LIM_MID    = FSZ_W'(MID_MAX);

    dmode_e mode_q, mode_d;

    // next-mode decision
    always_comb begin
        mode_d = mode_q;
        if (soft_rst) begin
            mode_d = DM_COMPAT;
        end else if (cfg_wr) begin
            if (!cfg_big)                     mode_d = DM_COMPAT;
            else if (cfg_fsize <= LIM_NARROW) mode_d = DM_NARROW;
            else if (cfg_fsize <= LIM_MID)    mode_d = DM_MID;
            else                              mode_d = DM_WIDE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= DM_COMPAT;
        else        mode_q <= mode_d;
    end

    // output: depth that holds after this edge
    always_comb begin
        unique case (mode_d)
            DM_COMPAT: depth_next = CW'(SMALL);
            DM_NARROW: depth_next = CW'(CAP);
            DM_MID:    depth_next = CW'(CAP / 2);
            DM_WIDE:   depth_next = CW'(CAP / 4);
            default:   depth_next = CW'(SMALL);
        endcase
    end

endmodule

// File: rtl/spi_fifo_ring.sv
module spi_fifo_ring
    import spi_fifo_pkg::*;
#(
    parameter int W   = 32,
    parameter int CAP = 32,
    localparam int PW = $clog2(CAP),
    localparam int CW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] depth_next,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic          full_next,
    output logic          drop
);

    logic [W-1:0]  mem [CAP];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q, cnt_d;
    occ_e          occ_q, occ_d;
    logic          accept, take;

    // next-state: occupancy class from next count and next depth
    always_comb begin
        accept = push && (occ_q != OCC_FULL);
        take   = pop  && (occ_q != OCC_EMPTY);
        cnt_d  = cnt_q + CW'(accept) - CW'(take);
        if (clr)                                    occ_d = OCC_EMPTY;
        else if (cnt_d == '0)                       occ_d = OCC_EMPTY;
        else if (cnt_d >= depth_next)               occ_d = OCC_FULL;
        else if (cnt_d == depth_next - CW'(1))      occ_d = OCC_NEAR;
        else                                        occ_d = OCC_PART;
    end

    // state register and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q  <= OCC_EMPTY;
            cnt_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            occ_q  <= OCC_EMPTY;
            cnt_q  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            occ_q <= occ_d;
            cnt_q <= cnt_d;
            if (accept) wr_ptr <= wr_ptr + PW'(1);
            if (take)   rd_ptr <= rd_ptr + PW'(1);
        end
    end

    // storage
    always_ff @(posedge clk) begin
        if (accept && !clr) mem[wr_ptr] <= wdata;
    end

    // outputs
    always_comb begin
        empty     = 1'b0;
        full      = 1'b0;
        full_next = 1'b0;
        unique case (occ_q)
            OCC_EMPTY: empty     = 1'b1;
            OCC_PART:  ;
            OCC_NEAR:  full_next = 1'b1;
            OCC_FULL:  full      = 1'b1;
            default:   ;
        endcase
        rdata = (occ_q == OCC_EMPTY) ? '0 : mem[rd_ptr];
        drop  = push && (occ_q == OCC_FULL);
    end

endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
    import spi_fifo_pkg::*;
#(
    parameter int W     = 32,
    parameter int CAP   = 32,
    parameter int SMALL = 4,
    parameter int FSZ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cfg_wr,
    input  logic             cfg_big,
    input  logic [FSZ_W-1:0] cfg_fsize,
    input  logic             tx_push,
    input  logic [W-1:0]     tx_wdata,
    input  logic             tx_pop,
    output logic [W-1:0]     tx_rdata,
    output logic             tx_empty,
    output logic             tx_full,
    output logic             tx_full_next,
    input  logic             rx_push,
    input  logic [W-1:0]     rx_wdata,
    input  logic             rx_pop,
    output logic [W-1:0]     rx_rdata,
    output logic             rx_empty,
    output logic             rx_full,
    output logic             rx_full_next,
    input  logic             ovf_clr,
    output logic             rx_ovf,
    output logic             rx_ovf_irq
);

    localparam int CW = $clog2(CAP) + 1;

    logic [CW-1:0] depth_next;
    logic          tx_drop_unused;
    logic          rx_drop;

    spi_fifo_depth_sel #(
        .CAP(CAP), .SMALL(SMALL), .FSZ_W(FSZ_W)
    ) u_depth (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_wr(cfg_wr), .cfg_big(cfg_big), .cfg_fsize(cfg_fsize),
        .depth_next(depth_next)
    );

    spi_fifo_ring #(.W(W), .CAP(CAP)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .depth_next(depth_next),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .empty(tx_empty), .full(tx_full), .full_next(tx_full_next),
        .drop(tx_drop_unused)
    );

    spi_fifo_ring #(.W(W), .CAP(CAP)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .depth_next(depth_next),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .empty(rx_empty), .full(rx_full), .full_next(rx_full_next),
        .drop(rx_drop)
    );

    // receive overflow: status cleared by a data read, interrupt by ovf_clr
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_ovf     <= 1'b0;
            rx_ovf_irq <= 1'b0;
        end else if (soft_rst) begin
            rx_ovf     <= 1'b0;
            rx_ovf_irq <= 1'b0;
        end else begin
            if (rx_drop)      rx_ovf <= 1'b1;
            else if (rx_pop)  rx_ovf <= 1'b0;
            if (rx_drop)      rx_ovf_irq <= 1'b1;
            else if (ovf_clr) rx_ovf_irq <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        cfg_wr,
    input logic        tx_push,
    input logic        tx_pop,
    input logic        tx_empty,
    input logic        tx_full,
    input logic        tx_full_next,
    input logic        rx_push,
    input logic        rx_pop,
    input logic        rx_empty,
    input logic        rx_full,
    input logic        ovf_clr,
    input logic        rx_ovf,
    input logic        rx_ovf_irq
);

    a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full && tx_push && !tx_pop && !soft_rst && !cfg_wr |=> tx_full);

    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_empty, tx_full, tx_full_next}));

    a_r5_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && rx_push && !soft_rst |=> rx_ovf && rx_ovf_irq);

    a_r6_pop_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && !rx_push && !soft_rst |=> !rx_ovf);

    a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_irq && !ovf_clr && !soft_rst |=> rx_ovf_irq);

    a_r7_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty && rx_pop && !rx_push && !soft_rst |=> rx_empty);

    a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> tx_empty && rx_empty && !rx_ovf && !rx_ovf_irq);

endmodule

bind spi_fifo_pair spi_fifo_pair_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
    .tx_push(tx_push), .tx_pop(tx_pop), .tx_empty(tx_empty),
    .tx_full(tx_full), .tx_full_next(tx_full_next),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_empty(rx_empty),
    .rx_full(rx_full), .ovf_clr(ovf_clr), .rx_ovf(rx_ovf),
    .rx_ovf_irq(rx_ovf_irq)
);

// File: tb/sim_spi_fifo_pair.sv
`timescale 1ns/1ps
module sim_spi_fifo_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0, cfg_wr = 1'b0, cfg_big = 1'b0;
    logic [5:0]  cfg_fsize = 6'd8;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0;
    logic [31:0] tx_rdata, rx_rdata;
    logic        tx_empty, tx_full, tx_full_next;
    logic        rx_empty, rx_full, rx_full_next, rx_ovf, rx_ovf_irq;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    spi_fifo_pair u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_wr(cfg_wr),
        .cfg_big(cfg_big), .cfg_fsize(cfg_fsize),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_empty(tx_empty), .tx_full(tx_full),
        .tx_full_next(tx_full_next),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_full_next(rx_full_next),
        .ovf_clr(ovf_clr), .rx_ovf(rx_ovf), .rx_ovf_irq(rx_ovf_irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_tx[$];
    logic [31:0] m_rx[$];
    int          m_depth = 4;
    bit          m_ovf = 0, m_irq = 0;

    function automatic int depth_for(bit big, int fs);
        if (!big)         return 4;
        else if (fs <= 8) return 32;
        else if (fs <= 16) return 16;
        else              return 8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            m_tx.delete(); m_rx.delete();
            m_depth = 4; m_ovf = 0; m_irq = 0;
        end else begin
            bit tx_acc, rx_acc, rx_drop;
            int nd;
            nd = cfg_wr ? depth_for(cfg_big, int'(cfg_fsize)) : m_depth;
            tx_acc  = tx_push && (m_tx.size() < m_depth);
            rx_drop = rx_push && (m_rx.size() >= m_depth);
            rx_acc  = rx_push && !rx_drop;
            if (tx_pop && m_tx.size() > 0) void'(m_tx.pop_front());
            if (tx_acc) m_tx.push_back(tx_wdata);
            if (rx_pop && m_rx.size() > 0) void'(m_rx.pop_front());
            if (rx_acc) m_rx.push_back(rx_wdata);
            if (rx_drop) m_ovf = 1; else if (rx_pop) m_ovf = 0;
            if (rx_drop) m_irq = 1; else if (ovf_clr) m_irq = 0;
            m_depth = nd;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            int ts, rs;
            ts = m_tx.size(); rs = m_rx.size();
            chk("R4 tx_empty", 32'(tx_empty), 32'(ts == 0));
            chk("R4 tx_full", 32'(tx_full), 32'(ts >= m_depth));
            chk("R4 tx_full_next", 32'(tx_full_next), 32'(ts == m_depth - 1));
            chk("R4 rx_empty", 32'(rx_empty), 32'(rs == 0));
            chk("R4 rx_full", 32'(rx_full), 32'(rs >= m_depth));
            chk("R4 rx_full_next", 32'(rx_full_next), 32'(rs == m_depth - 1));
            chk("R3 tx_rdata", tx_rdata, ts ? m_tx[0] : 32'h0);
            chk("R7 rx_rdata", rx_rdata, rs ? m_rx[0] : 32'h0);
            chk("R5 rx_ovf", 32'(rx_ovf), 32'(m_ovf));
            chk("R6 rx_ovf_irq", 32'(rx_ovf_irq), 32'(m_irq));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input bit big, input int fs);
        @(negedge clk); cfg_wr <= 1; cfg_big <= big; cfg_fsize <= 6'(fs);
        @(negedge clk); cfg_wr <= 0;
    endtask

    task automatic push_tx(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tx_push <= 1; tx_wdata <= base + 32'(i);
        end
        @(negedge clk); tx_push <= 0;
    endtask

    task automatic push_rx(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_push <= 1; rx_wdata <= base + 32'(i);
        end
        @(negedge clk); rx_push <= 0;
    endtask

    task automatic pop_tx_expect(input int n, input logic [31:0] base, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, tx_rdata, base + 32'(i));
            tx_pop <= 1;
        end
        @(negedge clk); tx_pop <= 0;
    endtask

    task automatic pop_rx_expect(input int n, input logic [31:0] base, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, rx_rdata, base + 32'(i));
            rx_pop <= 1;
        end
        @(negedge clk); rx_pop <= 0;
    endtask

    task automatic pulse_soft;
        @(negedge clk); soft_rst <= 1;
        @(negedge clk); soft_rst <= 0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n <= 1;
        @(negedge clk);
        // R8 reset state
        chk("R8 tx_empty", 32'(tx_empty), 1);
        chk("R8 rx_empty", 32'(rx_empty), 1);
        chk("R8 tx_full", 32'(tx_full), 0);
        chk("R8 rx_full", 32'(rx_full), 0);
        chk("R8 rx_ovf", 32'(rx_ovf), 0);

        // R1 default depth 4
        push_tx(3, 32'h100);
        chk("R4 tx_full_next at 3", 32'(tx_full_next), 1);
        chk("R1 not full at 3", 32'(tx_full), 0);
        push_tx(1, 32'h103);
        chk("R1 full at 4", 32'(tx_full), 1);
        push_tx(1, 32'hDEAD);                    // R3 discarded
        chk("R3 still full", 32'(tx_full), 1);
        pop_tx_expect(4, 32'h100, "R3 order kept");
        chk("R7 tx empty reads zero", tx_rdata, 0);

        // R1 with big clear and small frame
        cfg(0, 8);
        push_tx(4, 32'h200);
        chk("R1 cfg_big=0 full at 4", 32'(tx_full), 1);
        pop_tx_expect(4, 32'h200, "R1 drain");

        // R2 mappings
        cfg(1, 8);
        push_tx(31, 32'h300);
        chk("R2 fs8 full_next at 31", 32'(tx_full_next), 1);
        push_tx(1, 32'h31F);
        chk("R2 fs8 full at 32", 32'(tx_full), 1);
        pop_tx_expect(32, 32'h300, "R2 drain32");
        cfg(1, 9);
        push_tx(15, 32'h400);
        chk("R2 fs9 full_next at 15", 32'(tx_full_next), 1);
        push_tx(1, 32'h40F);
        chk("R2 fs9 full at 16", 32'(tx_full), 1);
        pop_tx_expect(16, 32'h400, "R2 drain16");
        cfg(1, 16);
        push_tx(16, 32'h500);
        chk("R2 fs16 full at 16", 32'(tx_full), 1);
        pop_tx_expect(16, 32'h500, "R2 drain16b");
        cfg(1, 17);
        push_tx(8, 32'h600);
        chk("R2 fs17 full at 8", 32'(tx_full), 1);
        pop_tx_expect(8, 32'h600, "R2 drain8");

        // R5 / R6 receive overflow
        cfg(0, 8);
        push_rx(4, 32'h700);
        chk("R5 rx_full", 32'(rx_full), 1);
        push_rx(1, 32'hBAD0);
        chk("R5 ovf status", 32'(rx_ovf), 1);
        chk("R5 ovf irq", 32'(rx_ovf_irq), 1);
        pop_rx_expect(1, 32'h700, "R5 word dropped");
        chk("R6 pop clears status", 32'(rx_ovf), 0);
        chk("R6 irq held", 32'(rx_ovf_irq), 1);
        pop_rx_expect(3, 32'h701, "R5 rest intact");
        @(negedge clk); ovf_clr <= 1;
        @(negedge clk); ovf_clr <= 0;
        chk("R6 ovf_clr clears irq", 32'(rx_ovf_irq), 0);

        // R7 pop of empty receive queue
        @(negedge clk); rx_pop <= 1;
        @(negedge clk); rx_pop <= 0;
        chk("R7 empty pop reads zero", rx_rdata, 0);
        chk("R7 still empty", 32'(rx_empty), 1);
        push_rx(1, 32'h800);
        chk("R7 single word", rx_rdata, 32'h800);
        pop_rx_expect(1, 32'h800, "R7 drain");

        // R10 shrink below occupancy
        cfg(1, 8);
        push_tx(20, 32'h900);
        cfg(1, 20);
        chk("R10 full after shrink", 32'(tx_full), 1);
        push_tx(1, 32'hBEEF);
        pop_tx_expect(13, 32'h900, "R10 drain order");
        chk("R10 near at 7", 32'(tx_full_next), 1);
        chk("R10 not full at 7", 32'(tx_full), 0);
        pop_tx_expect(7, 32'h90D, "R10 tail kept");

        // R11 simultaneous push and pop
        cfg(0, 8);
        push_tx(4, 32'hA00);
        @(negedge clk); tx_push <= 1; tx_pop <= 1; tx_wdata <= 32'hCAFE;
        @(negedge clk); tx_push <= 0; tx_pop <= 0;
        chk("R11 push refused when full", 32'(tx_full_next), 1);
        @(negedge clk); tx_push <= 1; tx_pop <= 1; tx_wdata <= 32'hA04;
        @(negedge clk); tx_push <= 0; tx_pop <= 0;
        chk("R11 push taken below depth", 32'(tx_full_next), 1);
        pop_tx_expect(2, 32'hA02, "R11 order");
        pop_tx_expect(1, 32'hA04, "R11 last");

        // R9 soft reset
        cfg(1, 8);
        push_tx(10, 32'hB00);
        push_rx(6, 32'hC00);
        pulse_soft();
        chk("R9 tx empty", 32'(tx_empty), 1);
        chk("R9 rx empty", 32'(rx_empty), 1);
        push_tx(4, 32'hD00);
        chk("R9 depth back to 4", 32'(tx_full), 1);
        pulse_soft();

        // random mix
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            tx_push  <= ($urandom_range(0, 99) < 45);
            tx_pop   <= ($urandom_range(0, 99) < 40);
            rx_push  <= ($urandom_range(0, 99) < 45);
            rx_pop   <= ($urandom_range(0, 99) < 35);
            tx_wdata <= $urandom;
            rx_wdata <= $urandom;
            ovf_clr  <= ($urandom_range(0, 99) < 5);
            cfg_wr   <= ($urandom_range(0, 99) < 3);
            cfg_big  <= ($urandom_range(0, 99) < 75);
            cfg_fsize <= 6'($urandom_range(0, 40));
            soft_rst <= ($urandom_range(0, 999) < 3);
        end
        @(negedge clk);
        {tx_push, tx_pop, rx_push, rx_pop, ovf_clr, cfg_wr, soft_rst} <= '0;
        idle(3);
        summary();
    end

endmodule